// File: doc/BRIEF.md
# Addressed Serial Register Interface

This block is the configuration port of a multi-register device. A host shifts 16-bit frames in over a data line and a serial clock, most significant bit first. A separate write strobe then commits whatever the last sixteen shifted bits are. Each frame holds a chip address, a read flag, a register index and ten data bits. Up to four devices can share the same serial lines because a frame only acts when its chip address matches the device's two address pins.

Eight ten-bit registers are held in flops and exported as one flat parallel bus, so downstream logic always sees the current settings. Some register bits are defined as always zero. A frame with the read flag set starts a serial read-back of the selected register on a dedicated output. While that read-back runs, no frame can change any register.

The serial lines are treated as slow asynchronous inputs. They are synchronised and edge-detected in the system clock domain, and every action happens on the system clock. A synchronous active-high reset restores the default register values.

Top module: `serreg_port`

## Requirements
- R1: After reset, registers 2 and 3 read 0x040, registers 4 and 5 read 0x050, registers 0, 1, 6 and 7 read 0x000, and `rdo` is 0.
- R2: On each rising `sclk` edge, `sdi` is shifted into a 16-bit frame, most significant bit first. On a rising `wrt` edge the frame is decoded as follows: bits 15:14 are the chip address, bit 13 is the read flag, bits 12:10 are the register index and bits 9:0 are the data. A frame with the read flag clear writes only the indexed register.
- R3: When more than 16 bits are shifted before `wrt` rises, only the last 16 bits form the frame.
- R4: A frame whose chip address differs from `chip_id` changes no register and starts no read-back.
- R5: A matching frame with the read flag set loads the indexed register into the read-back path. `rdo` then shows data bit 9 after the `wrt` edge, and each later rising `sclk` edge moves `rdo` to the next lower bit.
- R6: A frame committed while a read-back is in progress changes no register and does not restart the read-back.
- R7: Bits outside each register's writable mask are stored and read as zero. The masks are: register 0 0x1FF, register 1 0x0FF, registers 2 and 3 0x3FF, registers 4 and 5 0x0FF, register 6 0x07F, register 7 0x00F.
- R8: The 10th rising `sclk` edge after a read request ends the read-back. `rdo` then holds 0 and writes are accepted again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sclk | input | 1 | Serial shift clock, rising edge active |
| sdi | input | 1 | Serial data in |
| wrt | input | 1 | Frame commit strobe, rising edge active |
| chip_id | input | 2 | This device's chip address pins |
| rdo | output | 1 | Serial read-back data out |
| regs_flat | output | 80 | All eight registers; register i occupies bits [10*i+9:10*i] |

## Verification
Every cycle, the assertions check four things:
- the masked-zero bits of all eight registers;
- that a mismatched or read-busy commit leaves the whole register bank unchanged;
- that the shifter takes `sdi` into its low bit only on a detected `sclk` edge and holds otherwise;
- that `rdo` is low whenever no read-back is active.

Other behaviours show only in the bench's scenarios:
- that a write lands in the intended register with the right value;
- that only the last sixteen of an over-long burst count;
- the exact bit order and length of a read-back;
- that a frame formed from leftover bits during a read is rejected while the read continues.

// File: rtl/serreg_pkg.sv
package serreg_pkg;
  localparam int DATA_W  = 10;
  localparam int NREG    = 8;
  localparam int IDX_W   = 3;
  localparam int CHIP_W  = 2;
  localparam int FRAME_W = CHIP_W + 1 + IDX_W + DATA_W;

  typedef struct packed {
    logic [CHIP_W-1:0] chip;
    logic              rd;
    logic [IDX_W-1:0]  idx;
    logic [DATA_W-1:0] data;
  } frame_t;

  function automatic logic [DATA_W-1:0] reg_mask(input int i);
    case (i)
      0:       return DATA_W'(10'h1FF);
      1:       return DATA_W'(10'h0FF);
      2, 3:    return DATA_W'(10'h3FF);
      4, 5:    return DATA_W'(10'h0FF);
      6:       return DATA_W'(10'h07F);
      7:       return DATA_W'(10'h00F);
      default: return '0;
    endcase
  endfunction

  function automatic logic [DATA_W-1:0] reg_default(input int i);
    case (i)
      2, 3:    return DATA_W'(10'h040);
      4, 5:    return DATA_W'(10'h050);
      default: return '0;
    endcase
  endfunction
endpackage

// File: rtl/serreg_sync.sv
module serreg_sync #(
  parameter int WIDTH  = 1,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] chain [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < STAGES; s++) chain[s] <= '0;
    end else begin
      chain[0] <= d;
      for (int s = 1; s < STAGES; s++) chain[s] <= chain[s-1];
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/serreg_edge.sv
module serreg_edge #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] rise
);
  logic [WIDTH-1:0] lvl;
  logic [WIDTH-1:0] prev;

  serreg_sync #(.WIDTH(WIDTH), .STAGES(STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (d),
    .q   (lvl)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      prev <= '0;
      rise <= '0;
    end else begin
      prev <= lvl;
      rise <= lvl & ~prev;
    end
  end

  genvar g;
  generate
    for (g = 0; g < WIDTH; g++) begin : g_chk
      AST_RISE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        rise[g] |=> !rise[g]); // R2
    end
  endgenerate
endmodule

// File: rtl/serreg_shifter.sv
module serreg_shifter
  import serreg_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  logic   shift_i,
  input  logic   sdi_i,
  output frame_t frame_o
);
  logic [FRAME_W-1:0] sh;

  always_ff @(posedge clk) begin
    if (rst)          sh <= '0;
    else if (shift_i) sh <= {sh[FRAME_W-2:0], sdi_i};
  end

  assign frame_o = frame_t'(sh);

  AST_SHIFT_LSB: assert property (@(posedge clk) disable iff (rst)
    shift_i |=> sh[0] == $past(sdi_i)); // R2
  AST_SHIFT_HOLD: assert property (@(posedge clk) disable iff (rst)
    !shift_i |=> $stable(sh)); // R3
endmodule

// File: rtl/serreg_bank.sv
module serreg_bank
  import serreg_pkg::*;
(
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     commit_i,
  input  frame_t                   frame_i,
  input  logic [CHIP_W-1:0]        chip_id_i,
  input  logic                     busy_i,
  output logic                     rd_req_o,
  output logic [DATA_W-1:0]        rd_val_o,
  output logic [NREG*DATA_W-1:0]   regs_o
);
  logic [DATA_W-1:0] regs [NREG];
  logic              match;
  logic              wr_en;
  logic              rd_en;

  assign match = (frame_i.chip == chip_id_i);
  assign wr_en = commit_i && match && !frame_i.rd && !busy_i;
  assign rd_en = commit_i && match &&  frame_i.rd && !busy_i;

  genvar g;
  generate
    for (g = 0; g < NREG; g++) begin : g_reg
      always_ff @(posedge clk) begin
        if (rst)
          regs[g] <= reg_default(g);
        else if (wr_en && (int'(frame_i.idx) == g))
          regs[g] <= frame_i.data & reg_mask(g);
      end
      assign regs_o[g*DATA_W +: DATA_W] = regs[g];

      AST_FIXED_ZERO: assert property (@(posedge clk) disable iff (rst)
        (regs[g] & ~reg_mask(g)) == '0); // R7
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_req_o <= 1'b0;
      rd_val_o <= '0;
    end else begin
      rd_req_o <= rd_en;
      if (rd_en) begin
        if (int'(frame_i.idx) < NREG) rd_val_o <= regs[frame_i.idx];
        else                          rd_val_o <= '0;
      end
    end
  end

  AST_MISMATCH_KEEP: assert property (@(posedge clk) disable iff (rst)
    (commit_i && (frame_i.chip != chip_id_i)) |=> $stable(regs_o)); // R4
  AST_BUSY_KEEP: assert property (@(posedge clk) disable iff (rst)
    (commit_i && busy_i) |=> $stable(regs_o)); // R6
  AST_BUSY_NO_READ: assert property (@(posedge clk) disable iff (rst)
    (commit_i && busy_i) |=> !rd_req_o); // R6
endmodule

// File: rtl/serreg_readout.sv
module serreg_readout
  import serreg_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              load_i,
  input  logic [DATA_W-1:0] val_i,
  input  logic              shift_i,
  output logic              busy_o,
  output logic              rdo_o
);
  localparam int CW = $clog2(DATA_W);

  logic [DATA_W-1:0] sh;
  logic [CW-1:0]     cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_o <= 1'b0;
      rdo_o  <= 1'b0;
      sh     <= '0;
      cnt    <= '0;
    end else if (load_i) begin
      busy_o <= 1'b1;
      sh     <= val_i;
      rdo_o  <= val_i[DATA_W-1];
      cnt    <= CW'(DATA_W-1);
    end else if (shift_i && busy_o) begin
      if (cnt != '0) begin
        sh    <= {sh[DATA_W-2:0], 1'b0};
        rdo_o <= sh[DATA_W-2];
        cnt   <= cnt - 1'b1;
      end else begin
        busy_o <= 1'b0;
        rdo_o  <= 1'b0;
      end
    end
  end

  AST_IDLE_LOW: assert property (@(posedge clk) disable iff (rst)
    !busy_o |-> !rdo_o); // R8
  AST_FIRST_BIT: assert property (@(posedge clk) disable iff (rst)
    load_i |=> (busy_o && rdo_o == $past(val_i[DATA_W-1]))); // R5
endmodule

// File: rtl/serreg_port.sv
module serreg_port
  import serreg_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   sclk,
  input  logic                   sdi,
  input  logic                   wrt,
  input  logic [CHIP_W-1:0]      chip_id,
  output logic                   rdo,
  output logic [NREG*DATA_W-1:0] regs_flat
);
  logic [1:0]        rise;
  logic              sdi_s;
  frame_t            frame;
  logic              busy;
  logic              rd_req;
  logic [DATA_W-1:0] rd_val;

  serreg_edge #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_edge (
    .clk  (clk),
    .rst  (rst),
    .d    ({wrt, sclk}),
    .rise (rise)
  );

  serreg_sync #(.WIDTH(1), .STAGES(SYNC_STAGES)) u_sdi_sync (
    .clk (clk),
    .rst (rst),
    .d   (sdi),
    .q   (sdi_s)
  );

  serreg_shifter u_shift (
    .clk     (clk),
    .rst     (rst),
    .shift_i (rise[0]),
    .sdi_i   (sdi_s),
    .frame_o (frame)
  );

  serreg_bank u_bank (
    .clk       (clk),
    .rst       (rst),
    .commit_i  (rise[1]),
    .frame_i   (frame),
    .chip_id_i (chip_id),
    .busy_i    (busy),
    .rd_req_o  (rd_req),
    .rd_val_o  (rd_val),
    .regs_o    (regs_flat)
  );

  serreg_readout u_rd (
    .clk     (clk),
    .rst     (rst),
    .load_i  (rd_req),
    .val_i   (rd_val),
    .shift_i (rise[0]),
    .busy_o  (busy),
    .rdo_o   (rdo)
  );
endmodule

// File: tb/tb_serreg_port.sv
`timescale 1ns/1ps
module tb_serreg_port;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       sclk = 1'b0;
  logic       sdi = 1'b0;
  logic       wrt = 1'b0;
  logic [1:0] chip_id = 2'b10;
  logic       rdo;
  logic [79:0] regs_flat;

  int errors = 0;
  int checks = 0;
  bit done = 0;
  logic [9:0] model [8];

  always #2.5 clk = ~clk;

  serreg_port dut (
    .clk(clk), .rst(rst), .sclk(sclk), .sdi(sdi), .wrt(wrt),
    .chip_id(chip_id), .rdo(rdo), .regs_flat(regs_flat)
  );

  localparam int HALF = 5;
  localparam int NVEC = 10;
  // {frame[15:0], index[2:0], expected[9:0]}
  localparam logic [28:0] VEC [NVEC] = '{
    {2'b10, 1'b0, 3'd2, 10'h3FF, 3'd2, 10'h3FF},
    {2'b10, 1'b0, 3'd0, 10'h3FF, 3'd0, 10'h1FF},
    {2'b10, 1'b0, 3'd4, 10'h3AB, 3'd4, 10'h0AB},
    {2'b10, 1'b0, 3'd7, 10'h3FF, 3'd7, 10'h00F},
    {2'b10, 1'b0, 3'd6, 10'h155, 3'd6, 10'h055},
    {2'b10, 1'b0, 3'd1, 10'h2A5, 3'd1, 10'h0A5},
    {2'b10, 1'b0, 3'd3, 10'h001, 3'd3, 10'h001},
    {2'b10, 1'b0, 3'd5, 10'h100, 3'd5, 10'h000},
    {2'b01, 1'b0, 3'd2, 10'h000, 3'd2, 10'h3FF},
    {2'b11, 1'b0, 3'd3, 10'h3FF, 3'd3, 10'h001}
  };

  function automatic logic [9:0] bmask(input int i);
    case (i)
      0: return 10'h1FF;
      1: return 10'h0FF;
      2, 3: return 10'h3FF;
      4, 5: return 10'h0FF;
      6: return 10'h07F;
      default: return 10'h00F;
    endcase
  endfunction

  function automatic logic [9:0] bdef(input int i);
    case (i)
      2, 3: return 10'h040;
      4, 5: return 10'h050;
      default: return 10'h000;
    endcase
  endfunction

  task automatic chk(input string tag, input logic [79:0] act, input logic [79:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic sclk_pulse(input logic b);
    sdi = b;
    repeat (HALF) @(negedge clk);
    sclk = 1'b1;
    repeat (HALF) @(negedge clk);
    sclk = 1'b0;
  endtask

  task automatic wrt_pulse();
    repeat (HALF) @(negedge clk);
    wrt = 1'b1;
    repeat (HALF) @(negedge clk);
    wrt = 1'b0;
    repeat (HALF) @(negedge clk);
  endtask

  task automatic send(input logic [15:0] f);
    for (int b = 15; b >= 0; b--) sclk_pulse(f[b]);
    wrt_pulse();
  endtask

  task automatic chk_all(input string tag);
    logic [79:0] e;
    for (int i = 0; i < 8; i++) e[i*10 +: 10] = model[i];
    chk(tag, regs_flat, e);
  endtask

  task automatic apply_model(input logic [15:0] f);
    if (f[15:14] == chip_id && !f[13])
      model[int'(f[12:10])] = f[9:0] & bmask(int'(f[12:10]));
  endtask

  initial begin
    logic [9:0] rv;
    logic [15:0] f;
    for (int i = 0; i < 8; i++) model[i] = bdef(i);
    repeat (4) @(negedge clk);
    rst = 1'b0;
    repeat (2) @(negedge clk);

    // R1 reset values
    for (int i = 0; i < 8; i++)
      chk("R1 reset value", {70'd0, regs_flat[i*10 +: 10]}, {70'd0, bdef(i)});
    chk("R1 rdo idle", {79'd0, rdo}, 80'd0);

    // R2 R4 R7 vector table
    for (int v = 0; v < NVEC; v++) begin
      send(VEC[v][28:13]);
      apply_model(VEC[v][28:13]);
      chk("R2 R4 R7 target", {70'd0, regs_flat[int'(VEC[v][12:10])*10 +: 10]},
          {70'd0, VEC[v][9:0]});
      chk_all("R2 R4 whole bank");
    end

    // R3 over-long burst
    sclk_pulse(1'b1); sclk_pulse(1'b1); sclk_pulse(1'b0); sclk_pulse(1'b1);
    f = {2'b10, 1'b0, 3'd3, 10'h2C3};
    send(f);
    apply_model(f);
    chk_all("R3 last sixteen bits");

    // R4 mismatched read starts nothing
    send({2'b01, 1'b1, 3'd4, 10'd0});
    chk("R4 no read rdo", {79'd0, rdo}, 80'd0);
    sclk_pulse(1'b0);
    chk("R4 no read rdo after sclk", {79'd0, rdo}, 80'd0);
    sclk_pulse(1'b0);

    // R5 R8 full read-back of register 4
    rv = model[4];
    send({2'b10, 1'b1, 3'd4, 10'd0});
    chk("R5 first bit", {79'd0, rdo}, {79'd0, rv[9]});
    for (int k = 1; k <= 9; k++) begin
      sclk_pulse(1'b0);
      chk("R5 read bit", {79'd0, rdo}, {79'd0, rv[9-k]});
    end
    sclk_pulse(1'b0);
    chk("R8 rdo low after ten", {79'd0, rdo}, 80'd0);
    chk_all("R5 read leaves bank");

    // R6 commit during read: leftover bits form write of reg0 = 0x007
    send({2'b10, 1'b1, 3'd4, 10'd0});
    sclk_pulse(1'b1); sclk_pulse(1'b1); sclk_pulse(1'b1);
    wrt_pulse();
    chk_all("R6 write inhibited while reading");
    sclk_pulse(1'b0);
    chk("R6 read not restarted", {79'd0, rdo}, {79'd0, rv[5]});
    for (int k = 0; k < 6; k++) sclk_pulse(1'b0);
    chk("R8 read ended", {79'd0, rdo}, 80'd0);

    // R8 writes accepted again
    f = {2'b10, 1'b0, 3'd0, 10'h123};
    send(f);
    apply_model(f);
    chk_all("R8 write after read");

    // R1 reset again
    @(negedge clk); rst = 1'b1;
    repeat (3) @(negedge clk); rst = 1'b0;
    repeat (2) @(negedge clk);
    for (int i = 0; i < 8; i++) model[i] = bdef(i);
    chk_all("R1 reset restores defaults");
    chk("R1 rdo after reset", {79'd0, rdo}, 80'd0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule